// File: doc/BRIEF.md
# Pixel Plane Mask and Blink Gate

This block conditions pixel values on their way into a 256-entry color lookup. Five pixel ports are handled side by side in the same clock. Each port carries an 8-bit index. Every bit position of that index is a bit plane, and each plane can be switched off or made to blink.

Two host registers control the planes. The enable mask decides which planes may reach the palette address at all. The blink mask picks which of the enabled planes follow the blink phase. The blink phase arrives as a single input: high means the on phase and low means the off phase. Generating the blink rate and duty cycle is left to logic outside this block.

The host can write or read either register at any time, with no wait states. Neither register is cleared by reset, so software must load both after power-up. The conditioned indices leave the block through a register, one clock after the pixel inputs are sampled.

Top module: `pix_plane_gate`

## Requirements
- R1: Output bit i of every port is 0 whenever bit i of the enable mask is 0. When that mask bit is 1 and the plane is not blanked, output bit i equals input bit i.
- R2: Mask bit i acts on bit i of each port, and on all ports alike. Port k occupies bits [8k+7:8k] of the pixel buses.
- R3: When `blink_on` is 0, every plane whose blink-mask bit and enable-mask bit are both 1 is forced to 0 on all ports.
- R4: When `blink_on` is 1, the blink mask has no effect, and the output equals the input ANDed with the enable mask.
- R5: A plane whose enable-mask bit is 0 stays 0 in both blink phases, whatever its blink-mask bit holds.
- R6: A plane whose blink-mask bit is 0 and enable-mask bit is 1 passes its input in both blink phases.
- R7: `pix_out` reflects `pix_in` and `blink_on` as sampled at the previous rising clock edge. It does not change between edges.
- R8: A register written at one rising edge governs pixels sampled from the next rising edge onward. The pixel sampled at the write edge still uses the old value.
- R9: `hb_sel` = 0 selects the enable mask and `hb_sel` = 1 selects the blink mask. After a write with `hb_we` = 1, `hb_rdata` returns the written value in the same cycle, combinationally, with no wait state. A write to one register leaves the other register unchanged.
- R10: While `rst_n` is low, `pix_out` is 0 after each clock edge. Reset leaves both mask registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| hb_we | input | 1 | Host write strobe |
| hb_sel | input | 1 | Register select: 0 enable mask, 1 blink mask |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Selected register contents |
| blink_on | input | 1 | Blink phase: 1 on, 0 off |
| pix_in | input | 40 | Five 8-bit pixel indices, port k at [8k+7:8k] |
| pix_out | output | 40 | Five conditioned palette indices |

## Verification
The bench builds the block with its default parameters: 8-bit pixels on five ports. At this size every port is visible at once, so a single mask pattern can be checked against five different pixel values in the same cycle. The width is also small enough that fully-on, fully-off and mixed masks can all be written as single vectors. Directed tests cover the write-edge boundary, the one-cycle output latency, and whether the mask values survive a reset.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_BLINK  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/ppg_host_regs.sv
module ppg_host_regs
    import ppg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         we,
    input  logic         sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [W-1:0] en_mask,
    output logic [W-1:0] bl_mask
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] bl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (reg_sel_e'(sel))
                SEL_ENABLE: regs_d.en = wdata;
                SEL_BLINK:  regs_d.bl = wdata;
                default:    regs_d = regs_q;
            endcase
        end
    end

    // No reset: contents are undefined until software loads them.
    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rdata   = (reg_sel_e'(sel) == SEL_BLINK) ? regs_q.bl : regs_q.en;
    assign en_mask = regs_q.en;
    assign bl_mask = regs_q.bl;
endmodule

// File: rtl/ppg_phase_mask.sv
module ppg_phase_mask #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] en_mask,
    input  logic [W-1:0] bl_mask,
    input  logic         blink_on,
    output logic [W-1:0] eff_mask
);
    logic [W-1:0] blank_bits;

    always_comb begin
        blank_bits = blink_on ? '0 : (bl_mask & en_mask);
        eff_mask   = en_mask & ~blank_bits;
    end
endmodule

// File: rtl/ppg_port_stage.sv
module ppg_port_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pix_in,
    input  logic [W-1:0] eff_mask,
    output logic [W-1:0] pix_out
);
    typedef struct packed {
        logic [W-1:0] pix;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d.pix = pix_in & eff_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_out = st_q.pix;
endmodule

// File: rtl/pix_plane_gate.sv
module pix_plane_gate #(
    parameter int unsigned PIX_W     = 8,
    parameter int unsigned NUM_PORTS = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hb_we,
    input  logic                       hb_sel,
    input  logic [PIX_W-1:0]           hb_wdata,
    output logic [PIX_W-1:0]           hb_rdata,
    input  logic                       blink_on,
    input  logic [PIX_W*NUM_PORTS-1:0] pix_in,
    output logic [PIX_W*NUM_PORTS-1:0] pix_out
);
    logic [PIX_W-1:0] en_mask_w;
    logic [PIX_W-1:0] bl_mask_w;
    logic [PIX_W-1:0] eff_mask_w;

    ppg_host_regs #(.W(PIX_W)) regs_i (
        .clk     (clk),
        .we      (hb_we),
        .sel     (hb_sel),
        .wdata   (hb_wdata),
        .rdata   (hb_rdata),
        .en_mask (en_mask_w),
        .bl_mask (bl_mask_w)
    );

    ppg_phase_mask #(.W(PIX_W)) phase_i (
        .en_mask  (en_mask_w),
        .bl_mask  (bl_mask_w),
        .blink_on (blink_on),
        .eff_mask (eff_mask_w)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ppg_port_stage #(.W(PIX_W)) stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pix_in   (pix_in[p*PIX_W +: PIX_W]),
            .eff_mask (eff_mask_w),
            .pix_out  (pix_out[p*PIX_W +: PIX_W])
        );
    end
endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
    parameter int unsigned PIX_W     = 8,
    parameter int unsigned NUM_PORTS = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       hb_we,
    input logic                       hb_sel,
    input logic [PIX_W-1:0]           hb_wdata,
    input logic                       blink_on,
    input logic [PIX_W-1:0]           en_mask,
    input logic [PIX_W-1:0]           bl_mask,
    input logic [PIX_W*NUM_PORTS-1:0] pix_in,
    input logic [PIX_W*NUM_PORTS-1:0] pix_out
);
    p_disabled_plane_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pix_out & ~{NUM_PORTS{$past(en_mask)}}) == '0);

    p_blank_off_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(blink_on)) |->
            (pix_out & {NUM_PORTS{$past(en_mask & bl_mask)}}) == '0);

    p_on_phase_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blink_on)) |->
            pix_out == ($past(pix_in) & {NUM_PORTS{$past(en_mask)}}));

    p_steady_plane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
            (pix_out & {NUM_PORTS{$past(en_mask & ~bl_mask)}}) ==
            ($past(pix_in) & {NUM_PORTS{$past(en_mask & ~bl_mask)}}));

    p_write_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_we && !hb_sel) |=> (en_mask == $past(hb_wdata)) && $stable(bl_mask));

    p_write_blink_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_we && hb_sel) |=> (bl_mask == $past(hb_wdata)) && $stable(en_mask));

    p_hold_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_we |=> $stable(en_mask) && $stable(bl_mask));
endmodule

bind pix_plane_gate ppg_checker #(.PIX_W(PIX_W), .NUM_PORTS(NUM_PORTS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hb_we    (hb_we),
    .hb_sel   (hb_sel),
    .hb_wdata (hb_wdata),
    .blink_on (blink_on),
    .en_mask  (en_mask_w),
    .bl_mask  (bl_mask_w),
    .pix_in   (pix_in),
    .pix_out  (pix_out)
);

// File: tb/pix_plane_gate_tb_top.sv
module pix_plane_gate_tb_top;
    localparam int W  = 8;
    localparam int NP = 5;
    localparam int BW = W * NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hb_we = 1'b0;
    logic          hb_sel = 1'b0;
    logic [W-1:0]  hb_wdata = '0;
    logic [W-1:0]  hb_rdata;
    logic          blink_on = 1'b1;
    logic [BW-1:0] pix_in = '0;
    logic [BW-1:0] pix_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    pix_plane_gate #(.PIX_W(W), .NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .hb_we(hb_we), .hb_sel(hb_sel),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .blink_on(blink_on),
        .pix_in(pix_in), .pix_out(pix_out)
    );

    typedef struct packed {
        logic [W-1:0]  en;
        logic [W-1:0]  bl;
        logic          on;
        logic [BW-1:0] pix;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'hFF, 8'h00, 1'b0, 40'h01_23_45_67_89},  // R6 steady in off phase
        '{8'h0F, 8'h00, 1'b1, 40'hFF_FF_FF_FF_FF},  // R1
        '{8'hFF, 8'hF0, 1'b0, 40'hA5_5A_FF_00_C3},  // R3
        '{8'hFF, 8'hF0, 1'b1, 40'hA5_5A_FF_00_C3},  // R4
        '{8'h00, 8'hFF, 1'b1, 40'hFF_FF_FF_FF_FF},  // R5
        '{8'h3C, 8'hFF, 1'b0, 40'hFF_FF_FF_FF_FF},  // R5 with R3
        '{8'h81, 8'h01, 1'b0, 40'h80_01_81_7E_FF},  // R2 per port
        '{8'hAA, 8'h0F, 1'b1, 40'h12_34_56_78_9A}   // R4 with R1
    };

    function automatic logic [BW-1:0] model(input logic [BW-1:0] p,
                                            input logic [W-1:0] en,
                                            input logic [W-1:0] bl,
                                            input logic on);
        logic [BW-1:0] r;
        for (int k = 0; k < NP; k++)
            r[k*W +: W] = p[k*W +: W] & en & (on ? {W{1'b1}} : ~bl);
        return r;
    endfunction

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [W-1:0] v);
        @(negedge clk);
        hb_we = 1'b1; hb_sel = sel; hb_wdata = v;
        @(negedge clk);
        hb_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic sel, input logic [W-1:0] exp);
        hb_sel = sel;
        #1;
        chk(req, {{(BW-W){1'b0}}, hb_rdata}, {{(BW-W){1'b0}}, exp});
    endtask

    task automatic px(input logic [BW-1:0] p, input logic on);
        @(negedge clk);
        pix_in = p; blink_on = on;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got cycle %0d expected below 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset output", pix_out, '0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, VECS[i].en);
            wr(1'b1, VECS[i].bl);
            rd_chk("R9 enable readback", 1'b0, VECS[i].en);
            rd_chk("R9 blink readback", 1'b1, VECS[i].bl);
            px(VECS[i].pix, VECS[i].on);
            chk("R1/R2/R3/R4/R5/R6 vector", pix_out,
                model(VECS[i].pix, VECS[i].en, VECS[i].bl, VECS[i].on));
        end

        // R3 hand-computed: enable 0F, blink 03, off phase -> 0C per port
        wr(1'b0, 8'h0F);
        wr(1'b1, 8'h03);
        px(40'hFF_FF_FF_FF_FF, 1'b0);
        chk("R3 fixed", pix_out, 40'h0C_0C_0C_0C_0C);
        px(40'hFF_FF_FF_FF_FF, 1'b1);
        chk("R4 fixed", pix_out, 40'h0F_0F_0F_0F_0F);

        // R9: writing one register leaves the other
        wr(1'b1, 8'h77);
        rd_chk("R9 enable kept", 1'b0, 8'h0F);
        wr(1'b0, 8'h99);
        rd_chk("R9 blink kept", 1'b1, 8'h77);

        // R7: output holds between edges
        wr(1'b0, 8'hFF);
        wr(1'b1, 8'h00);
        px(40'h11_22_33_44_55, 1'b1);
        @(negedge clk);
        pix_in = 40'hAA_BB_CC_DD_EE;
        #1;
        chk("R7 no change before edge", pix_out, 40'h11_22_33_44_55);
        @(negedge clk);
        chk("R7 one edge later", pix_out, 40'hAA_BB_CC_DD_EE);

        // R8: write edge still uses the old mask
        pix_in = 40'hFF_FF_FF_FF_FF;
        hb_we = 1'b1; hb_sel = 1'b0; hb_wdata = 8'h0F;
        @(negedge clk);
        hb_we = 1'b0;
        chk("R8 old mask at write edge", pix_out, 40'hFF_FF_FF_FF_FF);
        rd_chk("R9 zero-wait read", 1'b0, 8'h0F);
        @(negedge clk);
        chk("R8 new mask next edge", pix_out, 40'h0F_0F_0F_0F_0F);

        // R10: reset keeps masks
        wr(1'b0, 8'h5A);
        wr(1'b1, 8'hC3);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 output cleared", pix_out, '0);
        rst_n = 1'b1;
        rd_chk("R10 enable retained", 1'b0, 8'h5A);
        rd_chk("R10 blink retained", 1'b1, 8'hC3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule